// File: doc/BRIEF.md
# SPI Host with Data-Ready Paced Responses

This block is an SPI master in mode 0 for a slow peripheral. The peripheral needs processing time after each command and reports readiness on an active-low data-ready line. A caller offers a command through a one-cycle strobe. The command holds a first byte, an optional second byte, and the number of response bytes to read back. The block drops slave select, waits a setup interval, and shifts the command bytes out most significant bit first. It keeps a programmable minimum quiet time between the two command bytes.

For each response byte the block waits for data-ready to go low, then clocks in one byte while sending 0x00. It presents the received byte on a one-cycle valid strobe and waits for data-ready to return high. Only then does it start the next byte or release slave select. A one-cycle done pulse closes the transfer. The wait for data-ready in either direction is limited by a programmable timeout. When the timeout expires, the block sets an error flag, releases slave select and finishes without emitting further bytes. Data-ready is passed through a two-stage synchronizer before use.

Top module: `spi_drdy_host`

## Requirements
- R1: After reset, `ss_n` is 1 and `sck`, `mosi`, `busy`, `done`, `rsp_valid` and `timeout_err` are 0. `sck` is 0 in every cycle in which `ss_n` is 1.
- R2: `sck` stays high for exactly `cfg_half_div` clock cycles per bit (0 counts as 1). `mosi` never changes in a cycle in which `sck` is high.
- R3: The first command byte is sent, MSB first, on every transfer. The second command byte follows only when `cmd_has_b1` is 1.
- R4: `ss_n` is low for the whole transfer and goes high only while `sck` is low. `ss_n` is high whenever `busy` is 0.
- R5: With two command bytes, `sck` stays low for at least `cfg_gap + cfg_half_div` cycles between the last falling edge of the first byte and the first rising edge of the second.
- R6: No response byte starts before data-ready has been low. Every response byte sends 0x00 on `mosi`.
- R7: After each response byte, neither a new byte nor the release of `ss_n` happens before data-ready has returned high.
- R8: Each response byte appears once on `rsp_data` with a one-cycle `rsp_valid`, assembled MSB first from `miso` sampled at `sck` rising edges. `miso` during command bytes yields no `rsp_valid`.
- R9: `busy` is 1 from the cycle after an accepted `cmd_valid` until `done`. `done` is a single-cycle pulse that comes after the last `rsp_valid`, in the cycle in which `busy` falls.
- R10: If data-ready does not change as awaited within `cfg_timeout` cycles, `timeout_err` rises, `ss_n` goes high in that same cycle, and `done` follows one cycle later. No further `rsp_valid` is produced. `timeout_err` stays set until the next accepted command.
- R11: `cmd_valid` is ignored while `busy` is 1.
- R12: With `cmd_rsp_cnt` 0, the transfer ends after the command bytes without waiting for data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_byte0 | input | 8 | First command byte |
| cmd_has_b1 | input | 1 | Send the second command byte |
| cmd_byte1 | input | 8 | Second command byte |
| cmd_rsp_cnt | input | RSP_W | Number of response bytes |
| cfg_half_div | input | DIV_W | Cycles per SCK half period |
| cfg_gap | input | GAP_W | Minimum idle cycles between command bytes |
| cfg_timeout | input | TO_W | Data-ready wait limit in cycles |
| miso | input | 1 | Serial data from the peripheral |
| drdy_n | input | 1 | Data-ready from the peripheral, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| ss_n | output | 1 | Slave select, active low |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_data | output | 8 | Response byte |
| done | output | 1 | Transfer finished pulse |
| busy | output | 1 | Transfer in progress |
| timeout_err | output | 1 | Last transfer ended on a timeout |

## Verification
The expiry of the data-ready timeout and the arrival of data-ready can land on the same controller cycle. The design lets data-ready win in that case. The bench provokes the collision by sweeping the delay at which its peripheral model pulls data-ready low across the timeout window. It judges each run against the arithmetic boundary: a delay, in cycles after the last command falling edge, of one less than the timeout must still yield the response byte, and a delay equal to the timeout or longer must give the error and no byte.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_TX0,
        ST_GAP,
        ST_TX1,
        ST_WRDY,
        ST_RX,
        ST_WHI,
        ST_FIN
    } sdh_state_e;

    typedef struct packed {
        logic [7:0] b0;
        logic       has_b1;
        logic [7:0] b1;
    } sdh_cmd_t;

    localparam logic [7:0] DUMMY_BYTE = 8'h00;

    // A zero half-period setting is treated as one cycle.
    function automatic logic [15:0] half_limit(input logic [15:0] d);
        return (d == 16'd0) ? 16'd1 : d;
    endfunction

endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdh_timer.sv
module sdh_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (ld)          cnt <= val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdh_shifter.sv
module sdh_shifter
    import sdh_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] half_div,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic [7:0]       rx,
    output logic             done
);
    logic             act;
    logic [7:0]       sh;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] hc;
    logic [DIV_W-1:0] lim;

    assign lim  = DIV_W'(half_limit(16'(half_div)));
    assign mosi = act & sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            sh   <= '0;
            bitn <= '0;
            hc   <= '0;
            sck  <= 1'b0;
            rx   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                sck <= 1'b0;
                if (start) begin
                    act  <= 1'b1;
                    sh   <= tx;
                    hc   <= '0;
                    bitn <= '0;
                end
            end else if (hc == lim - DIV_W'(1)) begin
                hc <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                hc <= hc + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdh_ctrl.sv
module sdh_ctrl
    import sdh_pkg::*;
#(
    parameter int RSP_W = 8,
    parameter int DIV_W = 8,
    parameter int GAP_W = 8,
    parameter int TO_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  sdh_cmd_t         cmd,
    input  logic [RSP_W-1:0] rsp_cnt,
    input  logic [DIV_W-1:0] half_div,
    input  logic [GAP_W-1:0] gap,
    input  logic [TO_W-1:0]  timeout,
    input  logic             drdy_s,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic             tmr_exp,
    output logic             tmr_ld,
    output logic [TO_W-1:0]  tmr_val,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    output logic             ss_n,
    output logic             busy,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             done,
    output logic             timeout_err
);
    sdh_state_e       st_q, st_n;
    sdh_cmd_t         cmd_q, cmd_n;
    logic [RSP_W-1:0] cnt_q, cnt_n;
    logic             ss_q, ss_nx;
    logic             busy_q, busy_n;
    logic             err_q, err_n;
    logic             start_q, start_n;
    logic [7:0]       tx_q, tx_n;
    logic             rv_q, rv_n;
    logic [7:0]       rd_q, rd_n;
    logic             done_q, done_n;
    logic             cmd_end;

    always_comb begin
        st_n    = st_q;
        cmd_n   = cmd_q;
        cnt_n   = cnt_q;
        ss_nx   = ss_q;
        busy_n  = busy_q;
        err_n   = err_q;
        tx_n    = tx_q;
        rd_n    = rd_q;
        start_n = 1'b0;
        rv_n    = 1'b0;
        done_n  = 1'b0;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        cmd_end = 1'b0;

        case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    cmd_n   = cmd;
                    cnt_n   = rsp_cnt;
                    busy_n  = 1'b1;
                    ss_nx   = 1'b0;
                    err_n   = 1'b0;
                    tmr_ld  = 1'b1;
                    tmr_val = TO_W'(half_div);
                    st_n    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    start_n = 1'b1;
                    tx_n    = cmd_q.b0;
                    st_n    = ST_TX0;
                end
            end
            ST_TX0: begin
                if (byte_done) begin
                    if (cmd_q.has_b1) begin
                        tmr_ld  = 1'b1;
                        tmr_val = TO_W'(gap);
                        st_n    = ST_GAP;
                    end else begin
                        cmd_end = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    start_n = 1'b1;
                    tx_n    = cmd_q.b1;
                    st_n    = ST_TX1;
                end
            end
            ST_TX1: begin
                if (byte_done) cmd_end = 1'b1;
            end
            ST_WRDY: begin
                if (!drdy_s) begin
                    start_n = 1'b1;
                    tx_n    = DUMMY_BYTE;
                    st_n    = ST_RX;
                end else if (tmr_exp) begin
                    err_n = 1'b1;
                    ss_nx = 1'b1;
                    st_n  = ST_FIN;
                end
            end
            ST_RX: begin
                if (byte_done) begin
                    rv_n    = 1'b1;
                    rd_n    = rx_byte;
                    cnt_n   = cnt_q - RSP_W'(1);
                    tmr_ld  = 1'b1;
                    tmr_val = timeout;
                    st_n    = ST_WHI;
                end
            end
            ST_WHI: begin
                if (drdy_s) begin
                    if (cnt_q == '0) begin
                        ss_nx = 1'b1;
                        st_n  = ST_FIN;
                    end else begin
                        tmr_ld  = 1'b1;
                        tmr_val = timeout;
                        st_n    = ST_WRDY;
                    end
                end else if (tmr_exp) begin
                    err_n = 1'b1;
                    ss_nx = 1'b1;
                    st_n  = ST_FIN;
                end
            end
            ST_FIN: begin
                done_n = 1'b1;
                busy_n = 1'b0;
                st_n   = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase

        if (cmd_end) begin
            if (cnt_q == '0) begin
                ss_nx = 1'b1;
                st_n  = ST_FIN;
            end else begin
                tmr_ld  = 1'b1;
                tmr_val = timeout;
                st_n    = ST_WRDY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cmd_q   <= '0;
            cnt_q   <= '0;
            ss_q    <= 1'b1;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            start_q <= 1'b0;
            tx_q    <= '0;
            rv_q    <= 1'b0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            cmd_q   <= cmd_n;
            cnt_q   <= cnt_n;
            ss_q    <= ss_nx;
            busy_q  <= busy_n;
            err_q   <= err_n;
            start_q <= start_n;
            tx_q    <= tx_n;
            rv_q    <= rv_n;
            rd_q    <= rd_n;
            done_q  <= done_n;
        end
    end

    assign sh_start    = start_q;
    assign sh_tx       = tx_q;
    assign ss_n        = ss_q;
    assign busy        = busy_q;
    assign rsp_valid   = rv_q;
    assign rsp_data    = rd_q;
    assign done        = done_q;
    assign timeout_err = err_q;
endmodule

// File: rtl/spi_drdy_host.sv
module spi_drdy_host
    import sdh_pkg::*;
#(
    parameter int RSP_W = 8,
    parameter int DIV_W = 8,
    parameter int GAP_W = 8,
    parameter int TO_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte0,
    input  logic             cmd_has_b1,
    input  logic [7:0]       cmd_byte1,
    input  logic [RSP_W-1:0] cmd_rsp_cnt,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic [TO_W-1:0]  cfg_timeout,
    input  logic             miso,
    input  logic             drdy_n,
    output logic             sck,
    output logic             mosi,
    output logic             ss_n,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             done,
    output logic             busy,
    output logic             timeout_err
);
    sdh_cmd_t        cmd_in;
    logic            drdy_s;
    logic            byte_done;
    logic [7:0]      rx_byte;
    logic            tmr_exp;
    logic            tmr_ld;
    logic [TO_W-1:0] tmr_val;
    logic            sh_start;
    logic [7:0]      sh_tx;

    assign cmd_in = '{b0: cmd_byte0, has_b1: cmd_has_b1, b1: cmd_byte1};

    sdh_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (drdy_n),
        .q   (drdy_s)
    );

    sdh_timer #(.W(TO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ld      (tmr_ld),
        .val     (tmr_val),
        .expired (tmr_exp)
    );

    sdh_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (sh_start),
        .tx       (sh_tx),
        .half_div (cfg_half_div),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .rx       (rx_byte),
        .done     (byte_done)
    );

    sdh_ctrl #(
        .RSP_W(RSP_W), .DIV_W(DIV_W), .GAP_W(GAP_W), .TO_W(TO_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd_in),
        .rsp_cnt     (cmd_rsp_cnt),
        .half_div    (cfg_half_div),
        .gap         (cfg_gap),
        .timeout     (cfg_timeout),
        .drdy_s      (drdy_s),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .tmr_exp     (tmr_exp),
        .tmr_ld      (tmr_ld),
        .tmr_val     (tmr_val),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .ss_n        (ss_n),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .done        (done),
        .timeout_err (timeout_err)
    );
endmodule

// File: rtl/sdh_checker.sv
module sdh_checker (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic sck,
    input logic mosi,
    input logic ss_n,
    input logic rsp_valid,
    input logic done,
    input logic busy,
    input logic timeout_err
);
    p_idle_sck_low_r1: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> !sck);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    p_release_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> !$past(sck));

    p_idle_deselect_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ss_n);

    p_valid_framed_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (busy && !ss_n));

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_from_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    p_err_release_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> ss_n);

    p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |=> done);
endmodule

bind spi_drdy_host sdh_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .sck         (sck),
    .mosi        (mosi),
    .ss_n        (ss_n),
    .rsp_valid   (rsp_valid),
    .done        (done),
    .busy        (busy),
    .timeout_err (timeout_err)
);

// File: tb/tb_spi_drdy_host.sv
module tb_spi_drdy_host;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte0 = '0;
    logic        cmd_has_b1 = 1'b0;
    logic [7:0]  cmd_byte1 = '0;
    logic [7:0]  cmd_rsp_cnt = '0;
    logic [7:0]  cfg_half_div = 8'd1;
    logic [7:0]  cfg_gap = '0;
    logic [31:0] cfg_timeout = 32'd1000;
    logic        miso = 1'b0;
    logic        drdy_n = 1'b1;
    logic        sck, mosi, ss_n, rsp_valid, done, busy, timeout_err;
    logic [7:0]  rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_drdy_host dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte0(cmd_byte0),
        .cmd_has_b1(cmd_has_b1), .cmd_byte1(cmd_byte1), .cmd_rsp_cnt(cmd_rsp_cnt),
        .cfg_half_div(cfg_half_div), .cfg_gap(cfg_gap), .cfg_timeout(cfg_timeout),
        .miso(miso), .drdy_n(drdy_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .busy(busy),
        .timeout_err(timeout_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rpat(input int t, input int i);
        return 8'h5A ^ 8'(t * 13 + i * 37 + 1);
    endfunction

    // peripheral model and monitor state
    int         txn_id, cur_div, ncmd, nrsp, rsp_given, rsp_seen, rsp_bad;
    int         bits, bytes_seen, nlog, lo_cnt, hi_cnt, d_lo, d_hi;
    int         viol6, viol7, hi_run, hi_bad, lo_run, gap_obs, done_cnt;
    bit         allow, hold, no_drdy;
    logic [7:0] cur_tx, sh_in;
    logic [7:0] log_b [0:15];
    logic       prev_sck, prev_ss;

    always @(negedge clk) begin
        if (rst) begin
            prev_sck = 1'b0;
            prev_ss  = 1'b1;
        end else begin
            if (hi_cnt > 0) begin
                hi_cnt--;
                if (hi_cnt == 0) begin drdy_n = 1'b1; hold = 0; end
            end
            if (lo_cnt > 0) begin
                lo_cnt--;
                if (lo_cnt == 0) begin
                    drdy_n = 1'b0;
                    allow  = 1;
                    cur_tx = rpat(txn_id, rsp_given);
                    rsp_given++;
                end
            end
            if (prev_ss && !ss_n) begin
                bits = 0; bytes_seen = 0; cur_tx = 8'hC3;
            end
            if (!prev_ss && ss_n) begin
                if (hold) viol7++;
                drdy_n = 1'b1; lo_cnt = 0; hi_cnt = 0; hold = 0; allow = 0;
            end
            if (sck && !prev_sck) begin
                if (bytes_seen >= ncmd && !allow) viol6++;
                if (hold) viol7++;
                sh_in = {sh_in[6:0], mosi};
                bits++;
                if (ncmd == 2 && bytes_seen == 1 && bits == 1) gap_obs = lo_run;
                hi_run = 0;
            end
            if (!sck && prev_sck) begin
                if (hi_run != cur_div) hi_bad++;
                lo_run = 0;
                if (bits == 8) begin
                    if (nlog < 16) log_b[nlog] = sh_in;
                    nlog++;
                    bits = 0;
                    bytes_seen++;
                    if (bytes_seen > ncmd) begin allow = 0; hold = 1; hi_cnt = d_hi; end
                    if (bytes_seen >= ncmd && rsp_given < nrsp && !no_drdy)
                        lo_cnt = (bytes_seen == ncmd) ? d_lo : d_hi + d_lo;
                end
            end
            if (sck) hi_run++; else lo_run++;
            miso = (bits < 8) ? cur_tx[7 - bits] : 1'b0;
            if (rsp_valid) begin
                if (rsp_data != rpat(txn_id, rsp_seen)) rsp_bad++;
                rsp_seen++;
            end
            if (done) done_cnt++;
            prev_sck = sck;
            prev_ss  = ss_n;
        end
    end

    task automatic run_txn(input int t, input logic [7:0] b0, input bit has1,
                           input logic [7:0] b1, input int n, input int div,
                           input int gap, input int to, input int dlo,
                           input bit nodrdy, input bit poke);
        int  w;
        bit  exp_err;
        int  nexp;
        int  nlog_snap;
        txn_id = t; cur_div = div; ncmd = has1 ? 2 : 1; nrsp = n;
        nlog = 0; rsp_given = 0; rsp_seen = 0; rsp_bad = 0; done_cnt = 0;
        viol6 = 0; viol7 = 0; hi_bad = 0; gap_obs = -1; no_drdy = nodrdy;
        d_lo = dlo; d_hi = 4; drdy_n = 1'b1; lo_cnt = 0; hi_cnt = 0;
        cfg_half_div = 8'(div); cfg_gap = 8'(gap); cfg_timeout = 32'(to);
        @(negedge clk);
        cmd_byte0 = b0; cmd_has_b1 = has1; cmd_byte1 = b1; cmd_rsp_cnt = 8'(n);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            cmd_byte0 = 8'hEE; cmd_rsp_cnt = 8'd5; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 20000, "R9", "done reached", w, 0);
        chk(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
        repeat (3) @(negedge clk);
        exp_err = (n > 0) && (nodrdy || dlo >= to);
        nexp = exp_err ? 0 : n;
        chk(timeout_err == exp_err, "R10", "error flag", int'(timeout_err), int'(exp_err));
        chk(rsp_seen == nexp, "R8", "response count", rsp_seen, nexp);
        chk(rsp_bad == 0, "R8", "response data mismatches", rsp_bad, 0);
        chk(nlog == ncmd + nexp, "R3", "bytes framed", nlog, ncmd + nexp);
        chk(log_b[0] == b0, "R3", "first command byte", int'(log_b[0]), int'(b0));
        if (has1)
            chk(log_b[1] == b1, "R3", "second command byte", int'(log_b[1]), int'(b1));
        for (int i = ncmd; i < nlog && i < 16; i++)
            chk(log_b[i] == 8'h00, "R6", "dummy byte", int'(log_b[i]), 0);
        chk(viol6 == 0, "R6", "clock before data-ready", viol6, 0);
        chk(viol7 == 0, "R7", "progress before data-ready high", viol7, 0);
        chk(hi_bad == 0, "R2", "sck high width errors", hi_bad, 0);
        if (has1)
            chk(gap_obs >= gap + div, "R5", "inter-byte low time", gap_obs, gap + div);
        if (n == 0)
            chk(nlog == ncmd && rsp_seen == 0, "R12", "no response phase", nlog, ncmd);
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        chk(ss_n == 1'b1 && sck == 1'b0, "R4", "released idle lines",
            int'({ss_n, sck}), 2);
        if (poke) begin
            nlog_snap = nlog;
            repeat (60) @(negedge clk);
            chk(nlog == nlog_snap && busy == 1'b0 && done_cnt == 1, "R11",
                "command while busy ignored", nlog, nlog_snap);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b1, "R1", "reset ss_n", int'(ss_n), 1);
        chk(sck == 1'b0 && mosi == 1'b0, "R1", "reset sck/mosi", int'({sck, mosi}), 0);
        chk(busy == 1'b0 && done == 1'b0 && rsp_valid == 1'b0 && timeout_err == 1'b0,
            "R1", "reset status", int'({busy, done, rsp_valid, timeout_err}), 0);
        t = 0;
        for (int div = 1; div <= 3; div++)
            for (int h = 0; h <= 1; h++)
                for (int n = 0; n <= 3; n++) begin
                    run_txn(t, 8'(8'h81 + t * 11), h[0], 8'(8'h3E ^ t), n, div,
                            6, 1000, 7, 1'b0, 1'b0);
                    t++;
                end
        // data-ready arrival swept across the timeout expiry (timeout 12)
        for (int d = 9; d <= 13; d++) begin
            run_txn(t, 8'hA7, 1'b0, 8'h00, 1, 2, 0, 12, d, 1'b0, 1'b0);
            t++;
        end
        // peripheral never signals ready
        run_txn(t, 8'h4C, 1'b1, 8'h19, 2, 1, 3, 30, 7, 1'b1, 1'b0);
        t++;
        // a second command offered mid-transfer
        run_txn(t, 8'h66, 1'b1, 8'h99, 2, 2, 4, 1000, 6, 1'b0, 1'b1);
        t++;
        // error flag cleared by the next good command
        run_txn(t, 8'h12, 1'b0, 8'h00, 1, 1, 0, 1000, 5, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule